// File: doc/BRIEF.md
# Serial Receiver with Per-Character Error Status

This block turns an asynchronous serial line into parallel characters. It watches the line on a 16x oversampling tick. A falling edge is accepted as a start bit only if the line is still low at the middle of that bit. The block then takes each data bit at its midpoint, least significant bit first, and checks an optional parity bit and the stop bit. Each finished character goes into a small receive queue as one entry. The entry holds the data byte and four flags: overrun, parity error, framing error and line break.

The frame shape comes from plain configuration inputs: word length, parity on or off, even or odd parity, and one or two stop bits. These settings are captured when a start bit is accepted, so a change during a character does not affect it. Two enables gate the start of new characters. Clearing either one during a character lets that character finish.

The queue is read through a valid/ready stream port. `m_valid` is high whenever the queue holds an entry. The head entry stays fixed until the consumer raises `m_ready`, and an entry is removed on each clock edge where `m_valid` and `m_ready` are both high. The receiver cannot be stalled. If a character completes while the queue is full, that character is dropped and the overrun flag is attached to the next character that is stored.

Top module: `uart_rx_errq`

## Requirements
- R1: A low level seen on a tick while idle is taken as a start bit only if the line is still low 8 ticks later, at mid-bit. If the line has gone high by then, the receiver returns to idle and stores nothing.
- R2: A frame has the following parts, in this order:
  - a start bit;
  - 5 to 8 data bits, least significant bit first, with `cfg_wlen` 0/1/2/3 selecting 5/6/7/8 bits;
  - an optional parity bit (`cfg_par_en`=1);
  - one stop bit, or two stop bits when `cfg_stop2`=1.

  Each bit is sampled 16 ticks after the previous sample.
- R3: When the word is shorter than 8 bits, the unused upper bits of `m_data` read as zero.
- R4: With parity enabled, `m_perr` is set when the count of ones over the data and parity bits is odd (`cfg_par_even`=1) or even (`cfg_par_even`=0). With parity disabled, `m_perr` is always 0.
- R5: `m_ferr` is set when the first stop bit is sampled low. A second stop bit is not checked.
- R6: `m_brk` is set, together with `m_ferr`, when every data bit, the parity bit (if enabled) and the first stop bit are all sampled low. The receiver then waits for the line to go high before it looks for a new start bit, so a long break yields exactly one entry.
- R7: A character that completes while the queue holds DEPTH entries is discarded. The next character that is stored carries `m_ovr`=1, and later characters carry `m_ovr`=0.
- R8: `m_valid` is high exactly when the queue is not empty, and `fifo_empty` is its inverse. While `m_valid` is high and `m_ready` is low, the head entry and `m_valid` hold. A handshake removes one entry. Entries come out in arrival order.
- R9: A new start bit is accepted only while both `en` and `rx_en` are high. A character already past its start bit completes and is stored even if an enable drops.
- R10: Reset empties the queue and clears any pending overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial line, idle high (synchronised inside) |
| tick16 | input | 1 | One-cycle pulse at 16x the bit rate |
| en | input | 1 | Block enable |
| rx_en | input | 1 | Receive enable |
| cfg_wlen | input | 2 | Word length: 0..3 means 5..8 bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd parity |
| cfg_stop2 | input | 1 | 1 = two stop bits |
| m_valid | output | 1 | Queue head entry is valid |
| m_ready | input | 1 | Consumer accepts head entry |
| m_data | output | 8 | Received character, upper bits zero |
| m_ovr | output | 1 | Overrun occurred before this character |
| m_perr | output | 1 | Parity error |
| m_ferr | output | 1 | Framing error |
| m_brk | output | 1 | Line break |
| fifo_empty | output | 1 | Queue empty |

## Verification
The bench builds the block with its defaults: OVS=16 ticks per bit and DEPTH=4 queue entries. With a depth of 4, the full-queue condition is reached after only four unread characters, so the dropped character and the overrun flag on its successor can be checked directly, and a reset during a pending overrun can be checked as well. The tick arrives every 4 clocks, so the two-stage synchroniser delay stays well inside one tick. This lets the mid-bit start check be probed with a pulse of only a few ticks, and lets a long break be seen to produce a single entry.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef struct packed {
    logic [7:0] data;
    logic       ovr;
    logic       perr;
    logic       ferr;
    logic       brk;
  } rx_entry_t;

  localparam int ENTRY_W = $bits(rx_entry_t);

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP,
    S_STOP2,
    S_WAITHI
  } rx_state_t;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b1;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_deframer.sv
module uart_rx_deframer
  import uart_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx,
  input  logic       tick,
  input  logic       go,
  input  logic [1:0] cfg_wlen,
  input  logic       cfg_par_en,
  input  logic       cfg_par_even,
  input  logic       cfg_stop2,
  input  logic       fifo_full,
  output logic       wr_en,
  output rx_entry_t  wr_entry
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] MID  = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  rx_state_t     state;
  logic [CW-1:0] cnt;
  logic [2:0]    bitn;
  logic [7:0]    shreg;
  logic          par_acc, par_bad, any_one, ovr_pend;
  logic [1:0]    wlen_q;
  logic          pe_q, even_q, stop2_q;
  logic          at_mid;

  assign at_mid = tick && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      bitn     <= '0;
      shreg    <= '0;
      par_acc  <= 1'b0;
      par_bad  <= 1'b0;
      any_one  <= 1'b0;
      ovr_pend <= 1'b0;
      wlen_q   <= 2'd3;
      pe_q     <= 1'b0;
      even_q   <= 1'b0;
      stop2_q  <= 1'b0;
      wr_en    <= 1'b0;
      wr_entry <= '0;
    end else begin
      wr_en <= 1'b0;
      if (tick && state != S_IDLE && state != S_WAITHI)
        cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      case (state)
        S_IDLE: begin
          if (tick && !rx && go) begin
            state <= S_START;
            cnt   <= '0;
          end
        end
        S_START: begin
          if (tick && cnt == MID) begin
            cnt <= '0;
            if (!rx) begin
              state   <= S_DATA;
              bitn    <= '0;
              shreg   <= '0;
              par_acc <= 1'b0;
              par_bad <= 1'b0;
              any_one <= 1'b0;
              wlen_q  <= cfg_wlen;
              pe_q    <= cfg_par_en;
              even_q  <= cfg_par_even;
              stop2_q <= cfg_stop2;
            end else begin
              state <= S_IDLE;
            end
          end
        end
        S_DATA: begin
          if (at_mid) begin
            shreg   <= {rx, shreg[7:1]};
            par_acc <= par_acc ^ rx;
            any_one <= any_one | rx;
            if (bitn == ({1'b0, wlen_q} + 3'd4))
              state <= pe_q ? S_PAR : S_STOP;
            else
              bitn <= bitn + 1'b1;
          end
        end
        S_PAR: begin
          if (at_mid) begin
            par_bad <= (par_acc ^ rx) ^ ~even_q;
            any_one <= any_one | rx;
            state   <= S_STOP;
          end
        end
        S_STOP: begin
          if (at_mid) begin
            if (fifo_full) begin
              ovr_pend <= 1'b1;
            end else begin
              wr_en         <= 1'b1;
              wr_entry.data <= shreg >> (2'd3 - wlen_q);
              wr_entry.ovr  <= ovr_pend;
              wr_entry.perr <= par_bad;
              wr_entry.ferr <= ~rx;
              wr_entry.brk  <= ~rx & ~any_one;
              ovr_pend      <= 1'b0;
            end
            if (!rx)          state <= S_WAITHI;
            else if (stop2_q) state <= S_STOP2;
            else              state <= S_IDLE;
          end
        end
        S_STOP2: begin
          if (at_mid) state <= S_IDLE;
        end
        S_WAITHI: begin
          if (rx) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_start_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_START && $past(state) == S_IDLE) |-> $past(go));

  p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ((16'(wr_entry.data) >> (int'(wlen_q) + 5)) == 16'd0));

  p_break_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_entry.brk) |-> wr_entry.ferr);

  p_no_write_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !$past(fifo_full));

  p_noparity_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !pe_q) |-> !wr_entry.perr);
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0]   PTR_LAST = AW'(DEPTH - 1);
  localparam logic [CNTW-1:0] CNT_FULL = CNTW'(DEPTH);

  logic [W-1:0]    mem [DEPTH];
  logic [AW-1:0]   wptr, rptr;
  logic [CNTW-1:0] count;
  logic            do_wr, do_rd;

  assign empty = (count == '0);
  assign full  = (count == CNT_FULL);
  assign do_wr = wr_en && !full;
  assign do_rd = rd_en && !empty;
  assign rd_data = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_wr) wptr <= (wptr == PTR_LAST) ? '0 : wptr + 1'b1;
      if (do_rd) rptr <= (rptr == PTR_LAST) ? '0 : rptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !full);
endmodule

// File: rtl/uart_rx_errq.sv
module uart_rx_errq
  import uart_rx_pkg::*;
#(
  parameter int OVS   = 16,
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_i,
  input  logic       tick16,
  input  logic       en,
  input  logic       rx_en,
  input  logic [1:0] cfg_wlen,
  input  logic       cfg_par_en,
  input  logic       cfg_par_even,
  input  logic       cfg_stop2,
  output logic       m_valid,
  input  logic       m_ready,
  output logic [7:0] m_data,
  output logic       m_ovr,
  output logic       m_perr,
  output logic       m_ferr,
  output logic       m_brk,
  output logic       fifo_empty
);
  logic      rx_s, wr_en, q_empty, q_full;
  rx_entry_t wr_entry, head;
  logic [ENTRY_W-1:0] head_bits;

  uart_rx_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rx_i), .q(rx_s)
  );

  uart_rx_deframer #(.OVS(OVS)) u_deframer (
    .clk(clk), .rst_n(rst_n), .rx(rx_s), .tick(tick16), .go(en & rx_en),
    .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en),
    .cfg_par_even(cfg_par_even), .cfg_stop2(cfg_stop2),
    .fifo_full(q_full), .wr_en(wr_en), .wr_entry(wr_entry)
  );

  uart_rx_fifo #(.DEPTH(DEPTH), .W(ENTRY_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_entry),
    .rd_en(m_ready & ~q_empty), .rd_data(head_bits),
    .empty(q_empty), .full(q_full)
  );

  assign head       = rx_entry_t'(head_bits);
  assign m_valid    = ~q_empty;
  assign fifo_empty = q_empty;
  assign m_data     = head.data;
  assign m_ovr      = head.ovr;
  assign m_perr     = head.perr;
  assign m_ferr     = head.ferr;
  assign m_brk      = head.brk;

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_ovr)
                               && $stable(m_perr) && $stable(m_ferr) && $stable(m_brk)));
endmodule

// File: tb/uart_rx_errq_test.sv
`timescale 1ns/1ps
module uart_rx_errq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx = 1'b1;
  logic tick = 1'b0;
  logic en = 1'b1, rx_en = 1'b1;
  logic [1:0] wlen = 2'd3;
  logic pe = 1'b0, even = 1'b0, stop2 = 1'b0;
  logic m_ready = 1'b0;
  logic m_valid, m_ovr, m_perr, m_ferr, m_brk, fifo_empty;
  logic [7:0] m_data;
  int tests = 0, fails = 0;
  int div = 0;

  always #10 clk = ~clk;

  always @(negedge clk) begin
    div  = (div == 3) ? 0 : div + 1;
    tick = (div == 0);
  end

  uart_rx_errq uut (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .tick16(tick), .en(en), .rx_en(rx_en),
    .cfg_wlen(wlen), .cfg_par_en(pe), .cfg_par_even(even), .cfg_stop2(stop2),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_ovr(m_ovr),
    .m_perr(m_perr), .m_ferr(m_ferr), .m_brk(m_brk), .fifo_empty(fifo_empty)
  );

  // {badstop, badpar, stop2, even, pe, wlen[1:0], data[7:0]}
  localparam logic [14:0] VEC [9] = '{
    15'h03A5, 15'h0F3C, 15'h2F3C, 15'h1781, 15'h275A,
    15'h00FF, 15'h1D6B, 15'h4255, 15'h43F0
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    repeat (n) @(posedge clk iff tick);
    #1;
  endtask

  task automatic send(input logic [7:0] d, input int nb, input bit badpar, input bit badstop);
    logic pbit;
    rx = 1'b0; wait_ticks(16);
    for (int i = 0; i < nb; i++) begin
      rx = d[i]; wait_ticks(16);
    end
    if (pe) begin
      pbit = ^(d & 8'((1 << nb) - 1));
      if (!even) pbit = ~pbit;
      if (badpar) pbit = ~pbit;
      rx = pbit; wait_ticks(16);
    end
    rx = ~badstop; wait_ticks(16);
    rx = 1'b1;
    if (stop2) wait_ticks(16);
    wait_ticks(16);
  endtask

  task automatic pop();
    @(negedge clk); m_ready = 1'b1;
    @(posedge clk); #1 m_ready = 1'b0;
  endtask

  task automatic expect_entry(input string tag, input logic [7:0] d,
                              input logic o, input logic p, input logic f, input logic b);
    @(negedge clk);
    chk({tag, " valid"}, 32'(m_valid), 32'd1);
    chk({tag, " data"}, 32'(m_data), 32'(d));
    chk({tag, " flags"}, 32'({m_ovr, m_perr, m_ferr, m_brk}), 32'({o, p, f, b}));
  endtask

  task automatic cfg8n1();
    wlen = 2'd3; pe = 1'b0; even = 1'b0; stop2 = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset valid", 32'(m_valid), 32'd0);
    chk("R10 reset empty", 32'(fifo_empty), 32'd1);

    // Table of frames: R2 R3 R4 R5
    for (int k = 0; k < 9; k++) begin
      logic [7:0] d, md;
      int nb;
      bit bs, bp, eperr, ebrk;
      d = VEC[k][7:0]; wlen = VEC[k][9:8]; pe = VEC[k][10]; even = VEC[k][11];
      stop2 = VEC[k][12]; bp = VEC[k][13]; bs = VEC[k][14];
      nb = int'(wlen) + 5;
      md = d & 8'((1 << nb) - 1);
      eperr = pe && bp;
      ebrk = bs && (md == 8'd0);
      send(d, nb, bp, bs);
      expect_entry($sformatf("R2/R3/R4/R5 vec%0d", k), md, 1'b0, eperr, bs, ebrk);
      repeat (5) @(negedge clk);
      chk("R8 hold while not ready", 32'({m_valid, m_data}), 32'({1'b1, md}));
      pop();
      @(negedge clk);
      chk("R8 empty after pop", 32'({m_valid, fifo_empty}), 32'b01);
    end

    // R1: short low pulse rejected
    cfg8n1();
    rx = 1'b0; wait_ticks(4); rx = 1'b1; wait_ticks(40);
    @(negedge clk);
    chk("R1 glitch no entry", 32'(m_valid), 32'd0);
    send(8'hC3, 8, 0, 0);
    expect_entry("R1 frame after glitch", 8'hC3, 0, 0, 0, 0);
    pop();

    // R6: long break gives one entry
    pe = 1'b1; even = 1'b1;
    rx = 1'b0; wait_ticks(16 * 16); rx = 1'b1; wait_ticks(48);
    expect_entry("R6 break", 8'h00, 0, 0, 1, 1);
    pop();
    @(negedge clk);
    chk("R6 single break entry", 32'(m_valid), 32'd0);
    cfg8n1();

    // R7: overrun
    for (int i = 0; i < 5; i++) send(8'h11 + 8'(i), 8, 0, 0);
    for (int i = 0; i < 4; i++) begin
      expect_entry("R7 kept entry", 8'h11 + 8'(i), 0, 0, 0, 0);
      pop();
    end
    @(negedge clk);
    chk("R7 dropped char absent", 32'(m_valid), 32'd0);
    send(8'h16, 8, 0, 0);
    expect_entry("R7 overrun flag on next", 8'h16, 1, 0, 0, 0);
    pop();
    send(8'h17, 8, 0, 0);
    expect_entry("R7 flag cleared after", 8'h17, 0, 0, 0, 0);
    pop();

    // R9: enable dropped mid-character
    fork
      send(8'h99, 8, 0, 0);
      begin wait_ticks(60); en = 1'b0; end
    join
    expect_entry("R9 char completes after disable", 8'h99, 0, 0, 0, 0);
    pop();
    send(8'h42, 8, 0, 0);
    @(negedge clk);
    chk("R9 en low no entry", 32'(m_valid), 32'd0);
    en = 1'b1; rx_en = 1'b0;
    send(8'h43, 8, 0, 0);
    @(negedge clk);
    chk("R9 rx_en low no entry", 32'(m_valid), 32'd0);
    rx_en = 1'b1;
    send(8'h77, 8, 0, 0);
    expect_entry("R9 re-enabled", 8'h77, 0, 0, 0, 0);
    pop();

    // R10: reset clears queue and pending overrun
    for (int i = 0; i < 5; i++) send(8'h20 + 8'(i), 8, 0, 0);
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R10 queue empty after reset", 32'({m_valid, fifo_empty}), 32'b01);
    send(8'h5E, 8, 0, 0);
    expect_entry("R10 no stale overrun", 8'h5E, 0, 0, 0, 0);
    pop();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule